// File: doc/BRIEF.md
# Pipelined Quadratic Evaluator

This block evaluates the polynomial y = a·x² + b·x + c on a stream of signed samples. It accepts one new sample on every clock cycle. The work is divided into three register-separated stages of similar depth. Stage one forms x² and b·x in parallel. Stage two forms a·x² and b·x + c. Stage three adds the two halves. Each sample moves through the stages with a valid flag, so the stream may contain idle cycles.

The three coefficients are sampled together with x in the cycle where the sample is accepted. A coefficient change therefore affects only the samples that arrive with it, and never a sample that is already in flight. The result keeps full precision: no bit is dropped or saturated at any stage. None of the arithmetic operators is pipelined internally; the stage registers alone set the cycle time.

Top module: `quad_pipe`

## Requirements
- R1: For each accepted sample, y_o equals a·x² + b·x + c computed exactly, as a signed two's-complement value of 3·DW+1 bits. x_i, a_i, b_i and c_i are signed two's-complement values of DW bits.
- R2: A sample is accepted on every rising clock edge at which in_valid_i is high. Samples on consecutive cycles produce results on consecutive cycles, in the same order.
- R3: out_valid_o is in_valid_i delayed by exactly three rising clock edges. The matching result appears on y_o in the same cycle that out_valid_o is high.
- R4: While rst_ni is low, out_valid_o and y_o are zero, asynchronously. Samples in flight when reset is applied are discarded. For the first three edges after release, out_valid_o stays low.
- R5: y_o does not change in any cycle where out_valid_o is low.
- R6: Each result uses the coefficients sampled at the same edge as its x. Coefficients applied at any other edge have no effect on that result.
- R7: The most negative and the most positive DW-bit input values give the exact result, including x = a = b = c = -2^(DW-1).
- R8: x_i and the coefficient inputs have no effect on the outputs at edges where in_valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample present on x_i this cycle |
| x_i | input | DW | Sample, signed |
| a_i | input | DW | Quadratic coefficient, signed |
| b_i | input | DW | Linear coefficient, signed |
| c_i | input | DW | Constant term, signed |
| out_valid_o | output | 1 | Result present on y_o this cycle |
| y_o | output | 3*DW+1 | Result, signed, full precision |

## Verification
The value and latency properties assume that in_valid_i and all data inputs are known (0 or 1, never X or Z) at every clock edge after reset. The bench meets this by driving defined values on every cycle, including random x and coefficients during idle cycles. The bench also assumes that reset is asserted from time zero and that any later reset is long enough for the delay history to restart cleanly. It keeps reset low for several edges each time, so the three-edge window the checker counts is never cut short.

// File: rtl/quad_pkg.sv
package quad_pkg;
  localparam int unsigned NUM_STAGES = 3;

  function automatic int unsigned sq_width(int unsigned dw);
    return 2 * dw;
  endfunction

  function automatic int unsigned prod_width(int unsigned dw);
    return 3 * dw;
  endfunction

  function automatic int unsigned res_width(int unsigned dw);
    return 3 * dw + 1;
  endfunction
endpackage

// File: rtl/quad_valid_pipe.sv
module quad_valid_pipe #(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic [DEPTH-1:0] valid_o
);
  logic [DEPTH-1:0] vq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vq[g] <= 1'b0;
        else         vq[g] <= valid_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vq[g] <= 1'b0;
        else         vq[g] <= vq[g-1];
      end
    end
  end

  assign valid_o = vq;
endmodule

// File: rtl/quad_stage1.sv
module quad_stage1 #(
  parameter int unsigned DW = 16,
  localparam int unsigned SW = 2 * DW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [DW-1:0] c_i,
  output logic signed [SW-1:0] sq_o,
  output logic signed [SW-1:0] bx_o,
  output logic signed [DW-1:0] a_o,
  output logic signed [DW-1:0] c_o
);
  logic signed [SW-1:0] x_ext, b_ext, sq_d, bx_d;

  assign x_ext = $signed({{(SW-DW){x_i[DW-1]}}, x_i});
  assign b_ext = $signed({{(SW-DW){b_i[DW-1]}}, b_i});
  // both products fit SW bits exactly, including (-2^(DW-1))^2
  assign sq_d  = x_ext * x_ext;
  assign bx_d  = b_ext * x_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_o <= '0;
      bx_o <= '0;
      a_o  <= '0;
      c_o  <= '0;
    end else if (en_i) begin
      sq_o <= sq_d;
      bx_o <= bx_d;
      a_o  <= a_i;
      c_o  <= c_i;
    end
  end
endmodule

// File: rtl/quad_stage2.sv
module quad_stage2 #(
  parameter int unsigned DW = 16,
  localparam int unsigned SW = 2 * DW,
  localparam int unsigned PW = 3 * DW,
  localparam int unsigned LW = SW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [SW-1:0] sq_i,
  input  logic signed [SW-1:0] bx_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] c_i,
  output logic signed [PW-1:0] ax2_o,
  output logic signed [LW-1:0] lin_o
);
  logic signed [PW-1:0] a_ext, sq_ext, ax2_d;
  logic signed [LW-1:0] bx_ext, c_ext, lin_d;

  assign a_ext  = $signed({{(PW-DW){a_i[DW-1]}}, a_i});
  assign sq_ext = $signed({{(PW-SW){sq_i[SW-1]}}, sq_i});
  assign ax2_d  = a_ext * sq_ext;
  assign bx_ext = $signed({bx_i[SW-1], bx_i});
  assign c_ext  = $signed({{(LW-DW){c_i[DW-1]}}, c_i});
  assign lin_d  = bx_ext + c_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ax2_o <= '0;
      lin_o <= '0;
    end else if (en_i) begin
      ax2_o <= ax2_d;
      lin_o <= lin_d;
    end
  end
endmodule

// File: rtl/quad_stage3.sv
module quad_stage3 #(
  parameter int unsigned DW = 16,
  localparam int unsigned PW = 3 * DW,
  localparam int unsigned LW = 2 * DW + 1,
  localparam int unsigned YW = 3 * DW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [PW-1:0] ax2_i,
  input  logic signed [LW-1:0] lin_i,
  output logic signed [YW-1:0] y_o
);
  logic signed [YW-1:0] ax2_ext, lin_ext, y_d;

  assign ax2_ext = $signed({ax2_i[PW-1], ax2_i});
  assign lin_ext = $signed({{(YW-LW){lin_i[LW-1]}}, lin_i});
  assign y_d     = ax2_ext + lin_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   y_o <= '0;
    else if (en_i) y_o <= y_d;
  end
endmodule

// File: rtl/quad_pipe.sv
module quad_pipe
  import quad_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned SW = sq_width(DW),
  localparam int unsigned PW = prod_width(DW),
  localparam int unsigned LW = SW + 1,
  localparam int unsigned YW = res_width(DW)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [DW-1:0] c_i,
  output logic                 out_valid_o,
  output logic signed [YW-1:0] y_o
);
  logic [NUM_STAGES-1:0] vld;
  logic signed [SW-1:0]  s1_sq, s1_bx;
  logic signed [DW-1:0]  s1_a, s1_c;
  logic signed [PW-1:0]  s2_ax2;
  logic signed [LW-1:0]  s2_lin;

  quad_valid_pipe #(.DEPTH(NUM_STAGES)) u_vld (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .valid_o (vld)
  );

  quad_stage1 #(.DW(DW)) u_s1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_valid_i),
    .x_i    (x_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .c_i    (c_i),
    .sq_o   (s1_sq),
    .bx_o   (s1_bx),
    .a_o    (s1_a),
    .c_o    (s1_c)
  );

  quad_stage2 #(.DW(DW)) u_s2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (vld[0]),
    .sq_i   (s1_sq),
    .bx_i   (s1_bx),
    .a_i    (s1_a),
    .c_i    (s1_c),
    .ax2_o  (s2_ax2),
    .lin_o  (s2_lin)
  );

  quad_stage3 #(.DW(DW)) u_s3 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (vld[1]),
    .ax2_i  (s2_ax2),
    .lin_i  (s2_lin),
    .y_o    (y_o)
  );

  assign out_valid_o = vld[NUM_STAGES-1];
endmodule

// File: rtl/quad_pipe_chk.sv
module quad_pipe_chk #(
  parameter int unsigned DW = 16,
  localparam int unsigned YW = 3 * DW + 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_valid_i,
  input logic signed [DW-1:0] x_i,
  input logic signed [DW-1:0] a_i,
  input logic signed [DW-1:0] b_i,
  input logic signed [DW-1:0] c_i,
  input logic                 out_valid_o,
  input logic signed [YW-1:0] y_o
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1 R6
  y_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (longint'(y_o) ==
      longint'($past(a_i, 3)) * longint'($past(x_i, 3)) * longint'($past(x_i, 3)) +
      longint'($past(b_i, 3)) * longint'($past(x_i, 3)) + longint'($past(c_i, 3))));

  // R3
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (out_valid_o == $past(in_valid_i, 3)));

  // R4
  startup_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 2'd3) |-> !out_valid_o);

  // R4
  always @(posedge clk_i) begin
    if (!rst_ni) reset_clear_chk: assert (!out_valid_o && y_o == '0);
  end

  // R5
  y_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(y_o));
endmodule

bind quad_pipe quad_pipe_chk #(.DW(DW)) u_chk (.*);

// File: tb/quad_pipe_test.sv
module quad_pipe_test;
  localparam int unsigned DW = 16;
  localparam int unsigned YW = 3 * DW + 1;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    longint exp;
    int     due;
    string  tag;
  } item_t;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] x = '0, a = '0, b = '0, c = '0;
  logic                 out_valid;
  logic signed [YW-1:0] y;

  int     n_chk = 0, n_fail = 0, cyc = 0;
  bit     done = 1'b0;
  longint last_y = 0;
  item_t  sb[$];

  quad_pipe #(.DW(DW)) uut (
    .clk_i (clk), .rst_ni (rst_n), .in_valid_i (in_valid),
    .x_i (x), .a_i (a), .b_i (b), .c_i (c),
    .out_valid_o (out_valid), .y_o (y)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic longint quad(logic signed [DW-1:0] xv, av, bv, cv);
    return longint'(av) * longint'(xv) * longint'(xv) + longint'(bv) * longint'(xv) + longint'(cv);
  endfunction

  task automatic drive(bit v, logic signed [DW-1:0] xv, av, bv, cv, string tag);
    @(negedge clk);
    in_valid = v;
    x = xv; a = av; b = bv; c = cv;
    if (v) sb.push_back('{exp: quad(xv, av, bv, cv), due: cyc + 3, tag: tag});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++)
      drive(1'b0, DW'($urandom), DW'($urandom), DW'($urandom), DW'($urandom), "R8");
  endtask

  // monitor: scoreboard comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3 unexpected out_valid", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(it.due == cyc, "R3 latency", longint'(cyc), longint'(it.due));
          check(longint'(y) == it.exp, {"R1 value ", it.tag}, longint'(y), it.exp);
        end
        last_y = longint'(y);
      end else begin
        check(longint'(y) == last_y, "R5 hold", longint'(y), last_y);
        if (sb.size() != 0 && sb[0].due <= cyc)
          check(1'b0, "R3 missing out_valid", 0, 1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

  initial begin
    // R4: reset state
    repeat (3) @(negedge clk);
    check(!out_valid && y == '0, "R4 reset state", longint'(y), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!out_valid, "R4 quiet after release", longint'(out_valid), 0);
    end

    // R7 R2: extremes back to back
    drive(1'b1, MINV, MINV, MINV, MINV, "R7 all min");
    drive(1'b1, MAXV, MAXV, MAXV, MAXV, "R7 all max");
    drive(1'b1, MINV, MAXV, MINV, MAXV, "R7 mixed");
    drive(1'b1, MAXV, MINV, MAXV, MINV, "R7 mixed2");
    drive(1'b1, '0, MAXV, MAXV, MINV, "R7 x zero");
    drive(1'b1, -16'sd1, MINV, MINV, '0, "R7 x minus one");
    idle(5);

    // R6: coefficients change every sample, same x
    for (int i = 0; i < 8; i++)
      drive(1'b1, 16'sd300, DW'(i * 7 - 20), DW'(-i * 3), DW'(i * 1000), "R6 coeff per sample");
    idle(4);

    // R1 R8: random stream with gaps, garbage on idle cycles
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
      drive(1'b1, DW'($urandom), DW'($urandom), DW'($urandom), DW'($urandom), "R1 random");
    end

    // R2: long back-to-back burst
    for (int i = 0; i < 100; i++)
      drive(1'b1, DW'($urandom), DW'($urandom), DW'($urandom), DW'($urandom), "R2 burst");
    idle(6);
    check(sb.size() == 0, "R2 all results delivered", longint'(sb.size()), 0);

    // R4: reset with samples in flight
    drive(1'b1, 16'sd5, 16'sd1, 16'sd1, 16'sd1, "R4 flushed");
    drive(1'b1, 16'sd6, 16'sd1, 16'sd1, 16'sd1, "R4 flushed");
    @(negedge clk);
    in_valid = 1'b0;
    #(CLK_PERIOD / 4) rst_n = 1'b0;
    #1;
    check(!out_valid && y == '0, "R4 async clear", longint'(y), 0);
    sb.delete();
    last_y = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!out_valid, "R4 in-flight discarded", longint'(out_valid), 0);
    end

    // R1: stream after reset
    for (int i = 0; i < 50; i++)
      drive(1'b1, DW'($urandom), DW'($urandom), DW'($urandom), DW'($urandom), "R1 after reset");
    idle(6);
    check(sb.size() == 0, "R2 drain", longint'(sb.size()), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule